// File: doc/BRIEF.md
# Multi-Register Store Sequencer

This block writes a chosen group of registers from a sixteen-entry, 32-bit register file out to memory, one 16-bit bus word per handshake. A 16-bit selection mask picks the registers. Entries 0 to 7 of the register file hold data registers and entries 8 to 15 hold address registers. A size flag picks between storing only the low half of each register (word size) and storing both halves (long size). A mode flag picks between two walks. In the ascending walk the address comes from an outside calculation and counts up. In the descending (predecrement) walk the address is taken from an address register, counts down, and is written back to that register when the walk ends.

The controller is a five-state machine. IDLE waits for a start strobe and latches the mask, size, mode, address-register number and start address (the IDLE->SCAN transition). SCAN checks one mask bit per cycle. An empty mask takes SCAN->FINISH. A clear low bit discards that bit and stays in SCAN. A set low bit captures the register and takes SCAN->WR_FIRST. WR_FIRST presents the first word and waits for the acknowledge. It then goes WR_FIRST->WR_SECOND for long size, or WR_FIRST->SCAN for word size. WR_SECOND presents the second half and returns WR_SECOND->SCAN on acknowledge. FINISH raises done for one cycle, raises the writeback in predecrement mode, and goes FINISH->IDLE.

Top module: `mstore_seq`

## Requirements
- R1: After reset, wr_valid_o, done_o and wb_en_o are all 0.
- R2: The mask is always consumed from bit 0 upward, and every bit is discarded whether or not it was set. In ascending mode, mask bit i selects register file entry i. The first word goes to start_addr_i, and the address rises by 2 after each acknowledged word.
- R3: In predecrement mode, mask bit i selects entry 15-i. The walk starts from the current value of entry 8+areg_i with no extra adjustment. The address is lowered by 2 before each word is presented.
- R4: In word size (long_i=0), each selected register yields a single write whose data is bits 15:0 of that register.
- R5: In long size and ascending mode, bits 31:16 are written first at the lower address, then bits 15:0 at that address plus 2.
- R6: In long size and predecrement mode, bits 15:0 are written first at the higher address, then bits 31:16 at that address minus 2.
- R7: A walk ends as soon as the remaining mask is zero. An all-zero mask at start gives no write at all, followed by the done pulse.
- R8: When a predecrement walk ends, wb_en_o pulses together with done_o. It carries wb_idx_o = 8+areg and wb_data_o equal to the last written address, or the unchanged start value if nothing was written. Ascending walks never raise wb_en_o.
- R9: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_addr_o and wr_data_o stay unchanged. The walk advances only on a cycle where both are high.
- R10: done_o is high for exactly one cycle per accepted start. A start strobe that arrives while a walk is in progress has no effect, and inputs are sampled only on the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, honoured only in IDLE |
| mask_i | input | NREG (16) | Register selection mask |
| long_i | input | 1 | 1 = store both halves, 0 = low half only |
| predec_i | input | 1 | 1 = predecrement walk |
| areg_i | input | IDX_W-1 (3) | Address register number for predecrement |
| start_addr_i | input | REG_W (32) | First address for ascending walks |
| rf_rd_idx_o | output | IDX_W (4) | Register file read index |
| rf_rd_data_i | input | REG_W (32) | Register file read data (combinational) |
| wr_valid_o | output | 1 | Word write request |
| wr_addr_o | output | REG_W (32) | Word write address |
| wr_data_o | output | WORD_W (16) | Word write data |
| wr_ready_i | input | 1 | Memory acknowledge |
| wb_en_o | output | 1 | Address register writeback strobe |
| wb_idx_o | output | IDX_W (4) | Writeback register index |
| wb_data_o | output | REG_W (32) | Writeback value |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start strobe arriving in the middle of a walk, while a write is stalled. If the design wrongly accepted it, the fault would only appear as extra writes or a second done pulse. The bench throttles the acknowledge to one cycle in three or one in five, so long full-mask walks last many cycles. It raises start again partway through, with scrambled mask and mode inputs, and then checks that the write stream still matches the reference queue exactly and that only one done pulse appears. The same throttling leaves requests waiting, which exercises the hold-stable rule on every stalled cycle.

// File: rtl/mstore_pkg.sv
package mstore_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WR_FIRST,
        ST_WR_SECOND,
        ST_FINISH
    } mst_state_e;

endpackage

// File: rtl/mstore_mask_walker.sv
module mstore_mask_walker #(
    parameter int NREG = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             down_i,
    input  logic [NREG-1:0]  mask_i,
    input  logic             drop_i,
    output logic [NREG-1:0]  mask_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             empty_o,
    output logic             cur_sel_o
);

    logic [NREG-1:0]  mask_q;
    logic [IDX_W-1:0] idx_q;
    logic             down_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            idx_q  <= '0;
            down_q <= 1'b0;
        end else if (load_i) begin
            mask_q <= mask_i;
            idx_q  <= down_i ? IDX_W'(NREG - 1) : '0;
            down_q <= down_i;
        end else if (drop_i) begin
            mask_q <= mask_q >> 1;
            idx_q  <= down_q ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
        end
    end

    assign mask_o    = mask_q;
    assign idx_o     = idx_q;
    assign empty_o   = (mask_q == '0);
    assign cur_sel_o = mask_q[0];

    // R2: discarding a bit never adds selected registers
    assert_mask_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i && !load_i) |=> ($countones(mask_q) <= $past($countones(mask_q))));

endmodule

// File: rtl/mstore_addr_unit.sv
module mstore_addr_unit #(
    parameter int AW   = 32,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          down_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] bus_addr_o
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] addr_q;
    logic          down_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else if (load_i) begin
            addr_q <= load_val_i;
            down_q <= down_i;
        end else if (step_i) begin
            addr_q <= down_q ? (addr_q - STEP_V) : (addr_q + STEP_V);
        end
    end

    assign addr_o     = addr_q;
    assign bus_addr_o = down_q ? (addr_q - STEP_V) : addr_q;

endmodule

// File: rtl/mstore_seq.sv
module mstore_seq #(
    parameter int NREG   = 16,
    parameter int WORD_W = 16,
    localparam int REG_W  = 2 * WORD_W,
    localparam int IDX_W  = $clog2(NREG),
    localparam int AREG_W = IDX_W - 1,
    localparam int STEP   = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic              long_i,
    input  logic              predec_i,
    input  logic [AREG_W-1:0] areg_i,
    input  logic [REG_W-1:0]  start_addr_i,
    output logic [IDX_W-1:0]  rf_rd_idx_o,
    input  logic [REG_W-1:0]  rf_rd_data_i,
    output logic              wr_valid_o,
    output logic [REG_W-1:0]  wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    output logic              wb_en_o,
    output logic [IDX_W-1:0]  wb_idx_o,
    output logic [REG_W-1:0]  wb_data_o,
    output logic              done_o
);

    import mstore_pkg::*;

    mst_state_e state_q, state_d;

    logic              long_q, predec_q;
    logic [AREG_W-1:0] areg_q;
    logic [REG_W-1:0]  data_q;

    logic              load, step, drop, capture;
    logic [NREG-1:0]   mask_cur;
    logic [IDX_W-1:0]  idx_cur;
    logic              mask_empty, bit_sel;
    logic [REG_W-1:0]  addr_cur, bus_addr;
    logic              ack;

    assign ack = wr_valid_o && wr_ready_i;

    mstore_mask_walker #(.NREG(NREG)) walker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .down_i    (predec_i),
        .mask_i    (mask_i),
        .drop_i    (drop),
        .mask_o    (mask_cur),
        .idx_o     (idx_cur),
        .empty_o   (mask_empty),
        .cur_sel_o (bit_sel)
    );

    mstore_addr_unit #(.AW(REG_W), .STEP(STEP)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (predec_i ? rf_rd_data_i : start_addr_i),
        .down_i     (predec_i),
        .step_i     (step),
        .addr_o     (addr_cur),
        .bus_addr_o (bus_addr)
    );

    // next state and control strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        drop    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (mask_empty) begin
                    state_d = ST_FINISH;
                end else if (bit_sel) begin
                    capture = 1'b1;
                    state_d = ST_WR_FIRST;
                end else begin
                    drop = 1'b1;
                end
            end
            ST_WR_FIRST: begin
                if (ack) begin
                    step = 1'b1;
                    if (long_q) begin
                        state_d = ST_WR_SECOND;
                    end else begin
                        drop    = 1'b1;
                        state_d = ST_SCAN;
                    end
                end
            end
            ST_WR_SECOND: begin
                if (ack) begin
                    step    = 1'b1;
                    drop    = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            long_q   <= 1'b0;
            predec_q <= 1'b0;
            areg_q   <= '0;
            data_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                long_q   <= long_i;
                predec_q <= predec_i;
                areg_q   <= areg_i;
            end
            if (capture) begin
                data_q <= rf_rd_data_i;
            end
        end
    end

    // outputs
    always_comb begin
        wr_valid_o  = 1'b0;
        wr_data_o   = data_q[WORD_W-1:0];
        done_o      = 1'b0;
        wb_en_o     = 1'b0;
        rf_rd_idx_o = idx_cur;
        unique case (state_q)
            ST_IDLE: begin
                rf_rd_idx_o = {1'b1, areg_i};
            end
            ST_SCAN: begin
            end
            ST_WR_FIRST: begin
                wr_valid_o = 1'b1;
                wr_data_o  = (long_q && !predec_q) ? data_q[REG_W-1:WORD_W]
                                                   : data_q[WORD_W-1:0];
            end
            ST_WR_SECOND: begin
                wr_valid_o = 1'b1;
                wr_data_o  = predec_q ? data_q[REG_W-1:WORD_W]
                                      : data_q[WORD_W-1:0];
            end
            ST_FINISH: begin
                done_o  = 1'b1;
                wb_en_o = predec_q;
            end
            default: begin
            end
        endcase
    end

    assign wr_addr_o = bus_addr;
    assign wb_idx_o  = {1'b1, areg_q};
    assign wb_data_o = addr_cur;

    // R9: a stalled request holds every field
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R10: completion lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: writeback only with done and only to an address register
    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (done_o && wb_idx_o[IDX_W-1]));

    // R5 and R6: the two halves of a long go to adjacent words
    assert_pair_adjacent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_FIRST && ack && long_q) |=>
            (wr_valid_o && (wr_addr_o == (predec_q ? ($past(wr_addr_o) - REG_W'(STEP))
                                                   : ($past(wr_addr_o) + REG_W'(STEP))))));

    // R7: an empty mask never issues a write right after start
    assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && mask_i == '0) |=> !wr_valid_o);

endmodule

// File: tb/mstore_seq_tb.sv
module mstore_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic        lng = 1'b0;
    logic        predec = 1'b0;
    logic [2:0]  areg = '0;
    logic [31:0] saddr = '0;
    logic [3:0]  rf_idx;
    logic [31:0] rf_data;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ready = 1'b0;
    logic        wb_en;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;
    logic        done;

    logic [31:0] regs [16];
    assign rf_data = regs[rf_idx];

    always #(CLK_PERIOD/2) clk = ~clk;

    mstore_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask), .long_i(lng),
        .predec_i(predec), .areg_i(areg), .start_addr_i(saddr),
        .rf_rd_idx_o(rf_idx), .rf_rd_data_i(rf_data),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_ready_i(wr_ready), .wb_en_o(wb_en), .wb_idx_o(wb_idx),
        .wb_data_o(wb_data), .done_o(done)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int ready_mode = 0;
    int done_cnt = 0;
    int wb_seen = 0;
    string cur_tag = "R1";

    logic [47:0] exp_q[$];
    bit          exp_wb = 1'b0;
    logic [3:0]  exp_wb_idx = '0;
    logic [31:0] exp_wb_val = '0;

    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [15:0] hold_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference queue
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0:       wr_ready = 1'b1;
            1:       wr_ready = (cyc % 3 == 0);
            default: wr_ready = (cyc % 5 == 0);
        endcase
        if (rst_n) begin
            if (hold_pend)
                chk(wr_valid && wr_addr == hold_addr && wr_data == hold_data, "R9",
                    "stalled request changed", {wr_valid, 15'd0, wr_addr, wr_data},
                    {1'b1, 15'd0, hold_addr, hold_data});
            hold_pend = wr_valid && !wr_ready;
            hold_addr = wr_addr;
            hold_data = wr_data;
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected write", {16'd0, wr_addr, wr_data}, 64'd0);
                end else begin
                    logic [47:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data} == e, cur_tag, "write addr/data",
                        {16'd0, wr_addr, wr_data}, {16'd0, e});
                end
            end
            if (done) done_cnt++;
            if (wb_en) begin
                wb_seen++;
                chk(exp_wb && wb_idx == exp_wb_idx && wb_data == exp_wb_val, "R8",
                    "writeback idx/value", {28'd0, wb_idx, wb_data},
                    {28'd0, exp_wb_idx, exp_wb_val});
                regs[wb_idx] = wb_data;
            end
        end
    end

    task automatic build_expect(input logic [15:0] m, input bit lg, input bit pd,
                                input logic [2:0] ar, input logic [31:0] sa);
        logic [31:0] a;
        exp_q.delete();
        exp_wb = pd;
        exp_wb_idx = {1'b1, ar};
        a = pd ? regs[{1'b1, ar}] : sa;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                int r;
                r = pd ? 15 - i : i;
                if (pd) begin
                    a = a - 32'd2;
                    exp_q.push_back({a, regs[r][15:0]});
                    if (lg) begin
                        a = a - 32'd2;
                        exp_q.push_back({a, regs[r][31:16]});
                    end
                end else if (lg) begin
                    exp_q.push_back({a, regs[r][31:16]});
                    a = a + 32'd2;
                    exp_q.push_back({a, regs[r][15:0]});
                    a = a + 32'd2;
                end else begin
                    exp_q.push_back({a, regs[r][15:0]});
                    a = a + 32'd2;
                end
            end
        end
        exp_wb_val = a;
    endtask

    task automatic run_op(input logic [15:0] m, input bit lg, input bit pd,
                          input logic [2:0] ar, input logic [31:0] sa,
                          input int rmode, input bit poke, input string tag);
        int w;
        build_expect(m, lg, pd, ar, sa);
        done_cnt = 0;
        wb_seen = 0;
        cur_tag = tag;
        ready_mode = rmode;
        @(negedge clk);
        mask = m; lng = lg; predec = pd; areg = ar; saddr = sa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mask = ~m; lng = ~lg; predec = ~pd; areg = ~ar; saddr = ~sa;
        w = 0;
        while (done_cnt == 0 && w < 3000) begin
            @(negedge clk);
            w++;
            start = (poke && (w == 4 || w == 9));
        end
        start = 1'b0;
        if (done_cnt == 0) chk(1'b0, "R10", "done timeout", 64'(w), 64'd3000);
        repeat (5) @(negedge clk);
        chk(done_cnt == 1, "R10", {tag, " done pulses"}, 64'(done_cnt), 64'd1);
        chk(exp_q.size() == 0, tag, "writes missing", 64'(exp_q.size()), 64'd0);
        chk(wb_seen == (pd ? 1 : 0), "R8", {tag, " writeback count"}, 64'(wb_seen),
            64'(pd ? 1 : 0));
        chk(!wr_valid, tag, "idle after done", 64'(wr_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++)
            regs[i] = {8'hA0 + 8'(i), 8'h5C, 8'hE0 + 8'(i), 8'h17};
        regs[10] = 32'h0001_0000;
        regs[15] = 32'h0000_8040;
        regs[9]  = 32'h0000_0300;
        repeat (3) @(negedge clk);
        chk(!wr_valid && !done && !wb_en, "R1", "reset outputs",
            {61'd0, wr_valid, done, wb_en}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!wr_valid && !done && !wb_en, "R1", "outputs after release",
            {61'd0, wr_valid, done, wb_en}, 64'd0);

        run_op(16'h8421, 1'b0, 1'b0, 3'd0, 32'h0000_2000, 0, 1'b0, "R2 R4");
        run_op(16'h00F0, 1'b1, 1'b0, 3'd0, 32'h0000_4000, 1, 1'b0, "R5");
        run_op(16'hC003, 1'b0, 1'b1, 3'd7, 32'hDEAD_0000, 0, 1'b0, "R3 R4");
        run_op(16'hFFFF, 1'b1, 1'b1, 3'd2, 32'h0, 2, 1'b1, "R6 R10");
        run_op(16'h0000, 1'b1, 1'b0, 3'd0, 32'h0000_6000, 0, 1'b0, "R7");
        run_op(16'h0000, 1'b0, 1'b1, 3'd1, 32'h0, 1, 1'b0, "R7 R8");
        run_op(16'hFFFF, 1'b1, 1'b0, 3'd0, 32'h0000_8000, 2, 1'b1, "R9 R10");
        run_op(16'h0001, 1'b1, 1'b1, 3'd2, 32'h0, 1, 1'b0, "R3 R6");
        run_op(16'h8000, 1'b0, 1'b0, 3'd0, 32'h0000_A002, 0, 1'b0, "R2 R7");
        run_op(16'h5A5A, 1'b0, 1'b1, 3'd7, 32'h0, 2, 1'b1, "R3 R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule